// File: doc/BRIEF.md
# Exclusive Unload/Load Scan Sequencer

This block sequences test patterns through one scan chain of `CHAIN_LEN` cells. It never shifts a response out while a stimulus shifts in. Each pattern passes through separate phases. The captured response is shifted out first, then the next stimulus is shifted in, then one capture cycle follows. The first pattern has no unload phase, because the chain holds nothing worth observing yet. After the last capture, a final unload-only phase empties the chain.

While unloading, the block drives the chain input with the constant `FILL`. Cells that have already been emptied settle at that value and stop toggling. Each bit leaving the chain is compared in its own cycle with a bit from the expected-response stream. Any difference sets a mismatch flag that stays set until the next run.

Stimulus and expected-response bits arrive on valid/ready streams. A bit transfers on a cycle where valid and ready are both high. Ready depends only on the current phase and never on valid. A source may hold valid low for as long as it likes: the chain then stalls, because `shift_en` stays low. A source that raises valid must keep its data steady until the bit is accepted. Control and status pins are plain levels or pulses.

Top module: `scan_xsio_ctrl`

## Requirements
- R1: After reset, `busy`, `done`, `fail`, `capture`, `scan_en`, `shift_en`, `stim_ready` and `exp_ready` are all 0.
- R2: `start` is taken only while `busy` is 0, and `pat_count` is sampled in that cycle. A `start` pulse during a run has no effect on the run or on its length. With `pat_count` = 0, `done` pulses in the next cycle and no shift or capture occurs.
- R3: In a load phase, `stim_ready` and `scan_en` are 1 and `scan_in` equals `stim_data`. The chain shifts (`shift_en` = 1) exactly on stimulus transfers. Each load accepts exactly `CHAIN_LEN` bits. The first bit accepted ends in the cell nearest `scan_out`.
- R4: In an unload phase, `exp_ready` and `scan_en` are 1 and `scan_in` equals `FILL`. The chain shifts exactly on expected-bit transfers, and each unload takes exactly `CHAIN_LEN` bits. After the final unload, every cell holds `FILL`.
- R5: `stim_ready` and `exp_ready` are never 1 in the same cycle.
- R6: Each load is followed by exactly one capture cycle. In that cycle `capture` = 1, `scan_en` = 0 and `shift_en` = 0.
- R7: The order of phases is load, capture, then (unload, load, capture) repeated for each further pattern, then a final unload. An unload always comes directly after a capture.
- R8: On each unload transfer, `scan_out` is compared with `exp_data`. A difference sets `fail` one cycle later. `fail` then stays 1 until the next accepted `start` clears it.
- R9: `done` is a one-cycle pulse in the cycle after the last unload transfer. `busy` is 0 from the following cycle.
- R10: With both streams always valid, `done` is high exactly 2·CHAIN_LEN·P + P + 1 cycles after the cycle in which `start` is taken for P ≥ 1 patterns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a run (taken only while idle) |
| pat_count | input | CNT_W | Number of patterns in the run |
| stim_valid | input | 1 | Stimulus bit valid |
| stim_ready | output | 1 | Stimulus bit accepted when high with valid |
| stim_data | input | 1 | Stimulus bit |
| exp_valid | input | 1 | Expected-response bit valid |
| exp_ready | output | 1 | Expected bit accepted when high with valid |
| exp_data | input | 1 | Expected-response bit |
| scan_out | input | 1 | Bit leaving the last chain cell |
| scan_en | output | 1 | Chain in shift mode (low for capture) |
| shift_en | output | 1 | Chain advances one cell this cycle |
| scan_in | output | 1 | Bit entering the first chain cell |
| capture | output | 1 | One-cycle capture strobe |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| fail | output | 1 | Sticky response mismatch flag |

## Verification
The bench goes after four kinds of fault.

- **Phase order.** It counts load and unload transfers at each capture. A sequencer that unloaded before the first load, or loaded before unloading, breaks those counts.
- **Stalled streams.** Gaps in both streams show whether the chain advances on a stalled cycle. That shows up as wrong `scan_out` bits and a wrong end state.
- **Fill value.** A chain not filled during unload leaves nonzero cells after the final phase.
- **Mismatch flag.** One corrupted expected bit in an early pattern must keep `fail` high through the later, clean patterns, and `fail` must drop at the next start.

The bench also checks three edge cases: zero-pattern runs, a `start` during a run, and the exact cycle count with no stalls.

// File: rtl/scan_xsio_pkg.sv
package scan_xsio_pkg;
  typedef enum logic [2:0] {
    PH_IDLE = 3'd0,
    PH_LOAD = 3'd1,
    PH_CAPT = 3'd2,
    PH_UNLD = 3'd3,
    PH_FIN  = 3'd4
  } phase_t;
endpackage

// File: rtl/scan_bit_cnt.sv
// Counts shifted bits within one phase. It wraps on the last bit, so it is
// back at zero whenever a phase begins.
module scan_bit_cnt #(
  parameter int LEN = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic adv,
  output logic at_end
);
  localparam int W = (LEN > 1) ? $clog2(LEN) : 1;
  localparam logic [W-1:0] LAST = W'(LEN - 1);

  logic [W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt <= '0;
    else if (adv)
      cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
  end

  assign at_end = (cnt == LAST);
endmodule

// File: rtl/scan_phase_fsm.sv
module scan_phase_fsm
  import scan_xsio_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CNT_W-1:0] pat_count,
  input  logic             load_end,
  input  logic             unld_end,
  output phase_t           phase,
  output logic             start_acc
);
  // Patterns whose stimulus has not yet been loaded.
  logic [CNT_W-1:0] pat_left;
  phase_t           nxt;

  assign start_acc = start && (phase == PH_IDLE);

  always_comb begin
    nxt = phase;
    unique case (phase)
      PH_IDLE: if (start_acc) nxt = (pat_count == '0) ? PH_FIN : PH_LOAD;
      PH_LOAD: if (load_end)  nxt = PH_CAPT;
      PH_CAPT:                nxt = PH_UNLD;
      PH_UNLD: if (unld_end)  nxt = (pat_left == '0) ? PH_FIN : PH_LOAD;
      PH_FIN:                 nxt = PH_IDLE;
      default:                nxt = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase    <= PH_IDLE;
      pat_left <= '0;
    end else begin
      phase <= nxt;
      if (start_acc)
        pat_left <= pat_count;
      else if (load_end)
        pat_left <= pat_left - 1'b1;
    end
  end
endmodule

// File: rtl/scan_resp_cmp.sv
module scan_resp_cmp (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic chk,
  input  logic obs,
  input  logic ref_bit,
  output logic fail
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      fail <= 1'b0;
    else if (clr)
      fail <= 1'b0;
    else if (chk && (obs != ref_bit))
      fail <= 1'b1;
  end
endmodule

// File: rtl/scan_xsio_ctrl.sv
module scan_xsio_ctrl
  import scan_xsio_pkg::*;
#(
  parameter int   CHAIN_LEN = 16,
  parameter int   CNT_W     = 8,
  parameter logic FILL      = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CNT_W-1:0] pat_count,
  input  logic             stim_valid,
  output logic             stim_ready,
  input  logic             stim_data,
  input  logic             exp_valid,
  output logic             exp_ready,
  input  logic             exp_data,
  input  logic             scan_out,
  output logic             scan_en,
  output logic             shift_en,
  output logic             scan_in,
  output logic             capture,
  output logic             busy,
  output logic             done,
  output logic             fail
);
  phase_t phase;
  logic   start_acc;
  logic   at_end;
  logic   stim_fire;
  logic   exp_fire;

  assign stim_ready = (phase == PH_LOAD);
  assign exp_ready  = (phase == PH_UNLD);
  assign stim_fire  = stim_ready && stim_valid;
  assign exp_fire   = exp_ready && exp_valid;

  assign shift_en = stim_fire || exp_fire;
  assign scan_en  = stim_ready || exp_ready;
  assign scan_in  = stim_ready ? stim_data : FILL;
  assign capture  = (phase == PH_CAPT);
  assign busy     = (phase != PH_IDLE);
  assign done     = (phase == PH_FIN);

  scan_bit_cnt #(.LEN(CHAIN_LEN)) u_bits (
    .clk    (clk),
    .rst_n  (rst_n),
    .adv    (shift_en),
    .at_end (at_end)
  );

  scan_phase_fsm #(.CNT_W(CNT_W)) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .pat_count (pat_count),
    .load_end  (stim_fire && at_end),
    .unld_end  (exp_fire && at_end),
    .phase     (phase),
    .start_acc (start_acc)
  );

  scan_resp_cmp u_cmp (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (start_acc),
    .chk     (exp_fire),
    .obs     (scan_out),
    .ref_bit (exp_data),
    .fail    (fail)
  );
endmodule

// File: rtl/scan_xsio_chk.sv
module scan_xsio_chk #(
  parameter logic FILL = 1'b0
) (
  input logic clk,
  input logic rst_n,
  input logic start,
  input logic stim_valid,
  input logic stim_ready,
  input logic stim_data,
  input logic exp_valid,
  input logic exp_ready,
  input logic exp_data,
  input logic scan_out,
  input logic scan_en,
  input logic shift_en,
  input logic scan_in,
  input logic capture,
  input logic busy,
  input logic done,
  input logic fail
);
  assert_streams_exclusive_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(stim_ready && exp_ready));

  assert_load_passes_stim_R3: assert property (@(posedge clk) disable iff (!rst_n)
    stim_ready |-> (scan_in == stim_data) && scan_en && (shift_en == stim_valid));

  assert_unload_fills_R4: assert property (@(posedge clk) disable iff (!rst_n)
    exp_ready |-> (scan_in == FILL) && scan_en && (shift_en == exp_valid));

  assert_capture_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    capture |-> !scan_en && !shift_en);

  assert_capture_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    capture |=> !capture);

  assert_unload_after_capture_R7: assert property (@(posedge clk) disable iff (!rst_n)
    capture |=> exp_ready);

  assert_load_entry_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stim_ready) |-> $past(exp_ready) || !$past(busy));

  assert_fail_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (fail && !(start && !busy)) |=> fail);

  assert_fail_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fail) |-> $past(exp_ready && exp_valid && (scan_out != exp_data)));

  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done && !busy);
endmodule

bind scan_xsio_ctrl scan_xsio_chk #(.FILL(FILL)) u_xsio_chk (
  .clk(clk), .rst_n(rst_n), .start(start),
  .stim_valid(stim_valid), .stim_ready(stim_ready), .stim_data(stim_data),
  .exp_valid(exp_valid), .exp_ready(exp_ready), .exp_data(exp_data),
  .scan_out(scan_out), .scan_en(scan_en), .shift_en(shift_en),
  .scan_in(scan_in), .capture(capture), .busy(busy), .done(done), .fail(fail)
);

// File: tb/test_scan_xsio_ctrl.sv
`timescale 1ns/1ps
module test_scan_xsio_ctrl;
  localparam int N = 8;
  localparam int CW = 8;
  localparam logic [N-1:0] MASK = 8'h96;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [CW-1:0] pat_count = '0;
  logic stim_valid = 1'b0, stim_data = 1'b0;
  logic exp_valid = 1'b0, exp_data = 1'b0;
  logic stim_ready, exp_ready, scan_en, shift_en, scan_in, capture, busy, done, fail;
  logic [N-1:0] chain = '0;
  wire scan_out = chain[N-1];

  always #4 clk = ~clk;  // 125 MHz

  scan_xsio_ctrl #(.CHAIN_LEN(N), .CNT_W(CW), .FILL(1'b0)) i_scan_xsio_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .pat_count(pat_count),
    .stim_valid(stim_valid), .stim_ready(stim_ready), .stim_data(stim_data),
    .exp_valid(exp_valid), .exp_ready(exp_ready), .exp_data(exp_data),
    .scan_out(scan_out), .scan_en(scan_en), .shift_en(shift_en),
    .scan_in(scan_in), .capture(capture), .busy(busy), .done(done), .fail(fail));

  // Behavioural chain with a simple logic-under-test response at capture.
  always @(posedge clk) begin
    if (capture) chain <= {chain[N-2:0], chain[N-1]} ^ MASK;
    else if (scan_en && shift_en) chain <= {chain[N-2:0], scan_in};
  end

  function automatic logic [N-1:0] resp(input logic [N-1:0] p);
    return {p[N-2:0], p[N-1]} ^ MASK;
  endfunction

  int nchk = 0, nfail = 0;
  logic sq[$];   // stimulus bits to feed
  logic xq[$];   // expected bits to feed (may be corrupted)
  logic tq[$];   // true response bits for the monitor
  bit gaps = 0;
  int cyc = 0, gapc = 0;
  int n_ld = 0, n_ul = 0, n_cap = 0;
  int done_cyc = -1, start_cyc = -1;
  bit cap_prev = 0;

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  // Driver: queues a pattern's stimulus and the response it must produce.
  task automatic push_pat(input logic [N-1:0] p, input bit corrupt_bit);
    for (int i = N - 1; i >= 0; i--) sq.push_back(p[i]);
  endtask
  task automatic push_resp(input logic [N-1:0] p, input bit corrupt);
    logic [N-1:0] r;
    r = resp(p);
    for (int i = N - 1; i >= 0; i--) begin
      tq.push_back(r[i]);
      xq.push_back((corrupt && i == N - 3) ? ~r[i] : r[i]);
    end
  endtask

  // Drive at negedge, sample 1 ns before the next posedge.
  always @(negedge clk) begin
    gapc++;
    stim_valid <= (sq.size() != 0) && !(gaps && (gapc % 3 == 0));
    stim_data  <= (sq.size() != 0) ? sq[0] : 1'b0;
    exp_valid  <= (xq.size() != 0) && !(gaps && (gapc % 4 == 1));
    exp_data   <= (xq.size() != 0) ? xq[0] : 1'b0;
    #3;
    cyc++;
    if (!rst_n) begin
      cap_prev = 0;
    end else begin
      if (stim_valid && stim_ready) begin
        chk(scan_in == stim_data, "R3", scan_in, stim_data);
        chk(shift_en, "R3", shift_en, 1);
        void'(sq.pop_front());
        n_ld++;
      end
      if (exp_valid && exp_ready) begin
        chk(scan_in == 1'b0, "R4", scan_in, 0);
        chk(scan_out == tq[0], "R8", scan_out, tq[0]);
        void'(xq.pop_front());
        void'(tq.pop_front());
        n_ul++;
      end
      if ((stim_ready && !stim_valid) || (exp_ready && !exp_valid))
        chk(!shift_en, "R3", shift_en, 0);
      chk(!(stim_ready && exp_ready), "R5", stim_ready + exp_ready, 1);
      if (capture) begin
        n_cap++;
        chk(!scan_en && !shift_en && !cap_prev, "R6", {scan_en, shift_en, cap_prev}, 0);
        chk(n_ld == N * n_cap, "R7", n_ld, N * n_cap);
        chk(n_ul == N * (n_cap - 1), "R7", n_ul, N * (n_cap - 1));
      end
      cap_prev = capture;
      if (done) done_cyc = cyc;
    end
  end

  task automatic wait_samples(input int k);
    repeat (k) @(negedge clk);
  endtask

  task automatic run(input int p, input bit corrupt_first, input bit poke_busy,
                     input int fail_exp, input bit check_len);
    logic [N-1:0] pat;
    int t;
    n_ld = 0; n_ul = 0; n_cap = 0; done_cyc = -1;
    for (int k = 0; k < p; k++) begin
      pat = N'(8'h3C + 37 * k + 11 * p);
      push_pat(pat, 0);
      push_resp(pat, corrupt_first && k == 0);
    end
    @(negedge clk);
    start <= 1'b1;
    pat_count <= CW'(p);
    #3 start_cyc = cyc + 1;
    @(negedge clk);
    start <= 1'b0;
    #3;
    if (p > 0) chk(fail == 1'b0, "R8", fail, 0);
    t = 0;
    while (done_cyc < 0 && t < 5000) begin
      if (poke_busy && t == 20) begin
        start <= 1'b1; pat_count <= CW'(1);
      end
      if (poke_busy && t == 21) start <= 1'b0;
      @(negedge clk); #3; t++;
    end
    chk(done_cyc >= 0, "R9", done_cyc, 1);
    chk(n_ld == N * p && n_ul == N * p, "R2", n_ul, N * p);
    chk(n_cap == p, "R6", n_cap, p);
    chk(fail == fail_exp, "R8", fail, fail_exp);
    if (p > 0) chk(chain == '0, "R4", chain, 0);
    if (check_len)
      chk(done_cyc - start_cyc == 2 * N * p + p + 1, "R10", done_cyc - start_cyc, 2 * N * p + p + 1);
    @(negedge clk); #3;
    chk(!done && !busy, "R9", {done, busy}, 0);
  endtask

  initial begin
    wait_samples(3);
    #3;
    chk(!busy && !done && !fail && !capture, "R1", {busy, done, fail, capture}, 0);
    chk(!scan_en && !shift_en && !stim_ready && !exp_ready, "R1",
        {scan_en, shift_en, stim_ready, exp_ready}, 0);
    rst_n <= 1'b1;
    wait_samples(2);
    run(3, 0, 0, 0, 1);         // R10 clean run, cycle count
    run(1, 0, 0, 0, 1);         // single pattern: load, capture, unload only
    gaps = 1;
    run(3, 1, 0, 1, 0);         // R8 sticky through clean later patterns, stalls
    run(2, 0, 0, 0, 0);         // R8 cleared by next start
    gaps = 0;
    run(2, 0, 1, 0, 1);         // R2 start while busy ignored
    run(0, 0, 0, 0, 0);         // R2 zero patterns
    chk(done_cyc - start_cyc == 1, "R2", done_cyc - start_cyc, 1);
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    #1500000;
    nchk++; nfail++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule